// File: doc/BRIEF.md
# Two-Tier DMA Channel Priority Arbiter

This block decides which of several DMA channels gets the shared bus for the next data unit. Each channel supplies a request line, an enable bit and a 2-bit software priority level. A channel is a candidate only when it is enabled and requesting. The arbiter first finds the highest software level among the candidates. Among candidates at that level, the channel with the lowest index wins.

The decision is registered. The granted channel keeps the bus until it pulses its own unit-done line. Only then does a new arbitration take place. The result is given both as a one-hot grant vector and as a binary channel index, together with a valid flag.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `grant` is all zeros, `grant_valid` is low and `grant_idx` is 0 until the first arbitration.
- R2: A channel takes part only when both its `req` bit and its `en` bit are high. A request without enable, or an enable without request, is never granted.
- R3: Channel i's level is `level[2i+1:2i]`, encoded 0 = low, 1 = medium, 2 = high, 3 = very high. The winner always holds the numerically highest level among the candidates.
- R4: Among candidates at the highest level, the lowest channel index wins.
- R5: When there is no candidate at an arbitration point, the next state is `grant` = 0, `grant_valid` = 0 and `grant_idx` = 0.
- R6: An arbitration point is any cycle in which `grant_valid` is low, or in which `unit_done` is high for the currently granted channel. The result appears on the outputs at the following clock edge.
- R7: While a grant is held, the grant does not change. This holds whatever the requests do, including when the granted channel drops its request, and when `unit_done` pulses on other channels.
- R8: A change to any channel's level while a grant is held has no effect until the next arbitration point. At that point the new levels decide.
- R9: Whenever `grant_valid` is high, `grant` is one-hot and `grant_idx` is the binary index of its set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel transfer request |
| en | input | NUM_CH | Per-channel enable |
| level | input | 2*NUM_CH | Per-channel 2-bit priority level, channel i at bits 2i+1:2i |
| unit_done | input | NUM_CH | Per-channel pulse marking the end of the current data unit |
| grant | output | NUM_CH | One-hot grant, registered |
| grant_idx | output | $clog2(NUM_CH) | Binary index of the granted channel, 0 when idle |
| grant_valid | output | 1 | A grant is held |

## Verification
The directed patterns each target one rule:
- A single requester, to check the registered latency.
- Equal levels on channels 2, 4 and 6, to check the lower-index tie-break.
- A very-high channel that is requesting but disabled, to check that enable qualifies the request.
- Level rewrites and foreign done pulses during a held grant, to check that arbitration happens only at boundaries.
- An empty request set, to check the idle state.

A random phase then mixes requests, enables, levels and done pulses. It compares every cycle against a behavioural model. This catches orderings that the directed cases do not reach, such as a winner that re-requests and wins again at its own boundary.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [LVL_W-1:0] {
    LVL_LOW   = 2'd0,
    LVL_MED   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_VHIGH = 2'd3
  } lvl_e;
endpackage

// File: rtl/dpa_level_max.sv
module dpa_level_max
  import dpa_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [NUM_CH-1:0]       act,
  input  logic [NUM_CH*LVL_W-1:0] level,
  output lvl_t                    top_lvl
);
  // stage one: highest level present among active channels
  always_comb begin
    top_lvl = LVL_LOW;
    for (int i = 0; i < NUM_CH; i++) begin
      if (act[i] && (level[i*LVL_W +: LVL_W] > top_lvl)) begin
        top_lvl = level[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/dpa_fixed_pick.sv
module dpa_fixed_pick #(
  parameter int NUM_CH = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] cand,
  output logic [NUM_CH-1:0] win_oh,
  output logic [IDX_W-1:0]  win_idx,
  output logic              win_any
);
  logic [NUM_CH-1:0] ahead;

  // stage two: lowest index among candidates wins
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign ahead[g] = 1'b0;
    end else begin : g_rest
      assign ahead[g] = ahead[g-1] | cand[g-1];
    end
    assign win_oh[g] = cand[g] & ~ahead[g];
  end

  assign win_any = |cand;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (win_oh[i]) win_idx = win_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/dpa_grant_reg.sv
module dpa_grant_reg #(
  parameter int NUM_CH = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] win_oh,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              win_any,
  input  logic [NUM_CH-1:0] unit_done,
  output logic [NUM_CH-1:0] grant,
  output logic [IDX_W-1:0]  grant_idx,
  output logic              grant_valid
);
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              vld_q, vld_d;
  logic              arb_pt;

  assign arb_pt = !vld_q || (|(grant_q & unit_done));

  always_comb begin
    grant_d = grant_q;
    idx_d   = idx_q;
    vld_d   = vld_q;
    if (arb_pt) begin
      grant_d = win_oh;
      idx_d   = win_any ? win_idx : '0;
      vld_d   = win_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else if (arb_pt) begin
      grant_q <= grant_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
    end
  end

  assign grant       = grant_q;
  assign grant_idx   = idx_q;
  assign grant_valid = vld_q;

  // R7
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !(|(grant & unit_done))) |=> $stable(grant) && $stable(grant_idx));
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($onehot0(grant) && grant[grant_idx]));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0 && grant_idx == '0));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dpa_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req,
  input  logic [NUM_CH-1:0]       en,
  input  logic [NUM_CH*LVL_W-1:0] level,
  input  logic [NUM_CH-1:0]       unit_done,
  output logic [NUM_CH-1:0]       grant,
  output logic [IDX_W-1:0]        grant_idx,
  output logic                    grant_valid
);
  logic [NUM_CH-1:0] act, cand, win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any;
  lvl_t              top_lvl;

  assign act = req & en;

  dpa_level_max #(.NUM_CH(NUM_CH)) u_max (
    .act(act), .level(level), .top_lvl(top_lvl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    assign cand[g] = act[g] && (level[g*LVL_W +: LVL_W] == top_lvl);
  end

  dpa_fixed_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand(cand), .win_oh(win_oh), .win_idx(win_idx), .win_any(win_any)
  );

  dpa_grant_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk(clk), .rst_n(rst_n), .win_oh(win_oh), .win_idx(win_idx),
    .win_any(win_any), .unit_done(unit_done), .grant(grant),
    .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  // R3 and R4: the picked winner outranks every other active channel
  always_comb begin
    if (rst_n && win_any) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (act[i]) begin
          // R3
          winner_level_chk: assert (level[i*LVL_W +: LVL_W] <= level[win_idx*LVL_W +: LVL_W]);
          // R4
          winner_order_chk: assert ((level[i*LVL_W +: LVL_W] != level[win_idx*LVL_W +: LVL_W])
                                    || (IDX_W'(i) >= win_idx));
        end
      end
    end
  end

  // R2
  grant_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !$stable(grant)) |-> (|($past(act) & grant)));
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int N  = 7;
  localparam int IW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req, en, unit_done;
  logic [2*N-1:0] level;
  logic [N-1:0]   grant;
  logic [IW-1:0]  grant_idx;
  logic           grant_valid;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done_f = 0;
  string tag    = "R1";

  int m_vld, m_idx;

  always #2 clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .en(en), .level(level),
    .unit_done(unit_done), .grant(grant), .grant_idx(grant_idx),
    .grant_valid(grant_valid)
  );

  // behavioural reference: strict '>' keeps the lowest index on ties
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0;
      m_idx <= 0;
    end else if (m_vld == 0 || unit_done[m_idx]) begin
      automatic int best = -1;
      automatic int bl   = -1;
      for (int i = 0; i < N; i++) begin
        if (req[i] && en[i] && int'(level[2*i +: 2]) > bl) begin
          bl   = int'(level[2*i +: 2]);
          best = i;
        end
      end
      m_vld <= (best >= 0) ? 1 : 0;
      m_idx <= (best >= 0) ? best : 0;
    end
  end

  task automatic chk(string t, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d expected=%0d", t, got, exp);
    end
  endtask

  task automatic cmp_model();
    chk({tag, " valid"}, int'(grant_valid), m_vld);
    chk({tag, " idx"}, int'(grant_idx), m_idx);
    chk({tag, " grant"}, int'(grant), m_vld ? (1 << m_idx) : 0);
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic setl(int ch, int v);
    level[2*ch +: 2] = 2'(v);
  endtask

  task automatic pulse_done(int ch);
    unit_done = N'(1) << ch;
    tick();
    unit_done = '0;
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; en = '0; unit_done = '0; level = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 grant", int'(grant), 0);
    chk("R1 valid", int'(grant_valid), 0);
    rst_n = 1'b1;
    tick();

    // R6: single requester, visible one edge later
    tag = "R6";
    req[3] = 1; en[3] = 1;
    #1 chk("R6 not yet granted", int'(grant), 0);
    tick();
    chk("R6 idx", int'(grant_idx), 3);

    // R7: hold against higher requester, foreign done, request drop
    tag = "R7";
    req[0] = 1; en[0] = 1; setl(0, 3);
    tick();
    pulse_done(5);
    chk("R7 foreign done ignored", int'(grant_idx), 3);
    req[3] = 0;
    tick();
    chk("R7 held after req drop", int'(grant_idx), 3);
    pulse_done(3);
    chk("R3 very high wins", int'(grant_idx), 0);

    // R2: a disabled very-high channel is ignored
    tag = "R2";
    en[0] = 0; req[0] = 1; setl(0, 3);
    req[1] = 1; en[1] = 0;
    req[6] = 1; en[6] = 1; setl(6, 0);
    pulse_done(0);
    chk("R2 disabled skipped", int'(grant_idx), 6);

    // R4: equal levels, lowest index wins
    tag = "R4";
    req = '0; en = '0;
    for (int c = 2; c <= 6; c += 2) begin
      req[c] = 1; en[c] = 1; setl(c, 1);
    end
    pulse_done(6);
    chk("R4 tie lowest", int'(grant_idx), 2);

    // R8: level rewrite during hold has no effect until boundary
    tag = "R8";
    setl(6, 3);
    tick(); tick();
    chk("R8 held", int'(grant_idx), 2);
    pulse_done(2);
    chk("R8 new level applied", int'(grant_idx), 6);

    // R5: nothing to grant
    tag = "R5";
    req = '0;
    pulse_done(6);
    chk("R5 valid low", int'(grant_valid), 0);
    chk("R5 grant zero", int'(grant), 0);
    chk("R5 idx zero", int'(grant_idx), 0);

    // R9 / R3: random mix compared with the model every cycle
    tag = "R9";
    for (int k = 0; k < 400; k++) begin
      req = N'($urandom);
      en  = N'($urandom | $urandom);
      if (k % 5 == 0) level = (2*N)'($urandom);
      unit_done = N'($urandom) & N'($urandom);
      if ($urandom % 3 == 0 && m_vld != 0) unit_done = unit_done | (N'(1) << m_idx);
      tick();
    end
    unit_done = '0;
    finish_run();
  end
endmodule